// File: doc/BRIEF.md
# Line Overhead Defect Interrupt Controller

This block sits behind a SONET STS-1/STS-3 receive overhead processor. It collects eight indications from that processor and reduces them to one interrupt line. Five of the inputs are defect levels: loss of signal, severely errored frame, loss of frame, signal degrade and signal failure. A level raises an event each time it changes, on both declaration and clearance. The other three inputs are single-cycle error pulses: section parity error, line parity error and line remote error indication. Each pulse raises an event every time it occurs.

A host reaches two 8-bit registers through a small register port. One is an enable mask. The other is a sticky status register that is cleared when the host reads it. An event sets its status bit only when its enable bit is 1. The interrupt output is high while any status bit is set.

Top module: `loh_irq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, the status register reads 0x00 and `irqOut` is low.
- R2: A write with `regAddr`=0 loads the enable register. A read with `regAddr`=0 returns the enable register and `regAddr`=1 returns the status register; `regRdData` shows the selected register during the read cycle.
- R3: Bit positions, shared by the enable and status registers: bit0 loss of signal, bit1 severely errored frame, bit2 loss of frame, bit3 section parity error, bit4 line parity error, bit5 line remote error, bit6 signal degrade, bit7 signal failure.
- R4: When a defect level goes from 0 to 1 while its enable bit is 1, its status bit is set at the next clock edge.
- R5: When a defect level goes from 1 to 0 while its enable bit is 1, its status bit is set at the next clock edge.
- R6: A defect level that stays constant raises no further event.
- R7: Each cycle in which an error pulse input is high while its enable bit is 1 sets its status bit. The bit stays set across further pulses.
- R8: An event whose enable bit is 0 leaves its status bit clear and does not raise `irqOut`.
- R9: A read with `regAddr`=1 clears every status bit at the end of that cycle. A read with `regAddr`=0 leaves the status register unchanged.
- R10: An enabled event in the same cycle as a status read leaves its status bit set after the read.
- R11: `irqOut` goes high one clock after an enabled event. It stays high while any status bit is set and goes low one clock after a status read that clears the last set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| losDefect | input | 1 | Loss-of-signal defect level |
| sefDefect | input | 1 | Severely-errored-frame defect level |
| lofDefect | input | 1 | Loss-of-frame defect level |
| sdDefect | input | 1 | Signal-degrade defect level |
| sfDefect | input | 1 | Signal-failure defect level |
| secParityErr | input | 1 | Section parity error pulse |
| lineParityErr | input | 1 | Line parity error pulse |
| lineRemoteErr | input | 1 | Line remote error indication pulse |
| regAddr | input | 1 | Register select: 0 enable, 1 status |
| regWrEn | input | 1 | Write strobe |
| regRdEn | input | 1 | Read strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| irqOut | output | 1 | Active-high interrupt |

## Verification
The tests apply single level rises and single level falls, which show that both transitions are detected. A level is held steady across a read, which shows that the edge detector does not report an event on every cycle. Several levels change in the same cycle, which checks that each source lands on its own bit position. Repeated pulses check that the status bit stays set. An event with its enable bit at 0 checks the masking. A pulse in the same cycle as a status read separates a correct set-over-clear priority from a clear that wins. A read of the enable register, with an event pending, shows that only a status read clears the status register.

// File: rtl/loh_irq_pkg.sv
package loh_irq_pkg;
  localparam int SRC_W = 8;

  // bit positions shared by the enable and status registers
  localparam int LOS_BIT = 0;
  localparam int SEF_BIT = 1;
  localparam int LOF_BIT = 2;
  localparam int SEC_BIT = 3;
  localparam int LINE_BIT = 4;
  localparam int REM_BIT = 5;
  localparam int SD_BIT = 6;
  localparam int SF_BIT = 7;

  // sources that are levels (change-detected), the rest are pulses
  localparam logic [SRC_W-1:0] LEVEL_MASK =
    SRC_W'((1 << LOS_BIT) | (1 << SEF_BIT) | (1 << LOF_BIT) | (1 << SD_BIT) | (1 << SF_BIT));

  localparam logic ENABLE_ADDR = 1'b0;
  localparam logic STATUS_ADDR = 1'b1;

  typedef struct packed {
    logic wrEnable;
    logic clrStatus;
    logic selStatus;
  } regStrobes_t;
endpackage

// File: rtl/loh_irq_ctrl_unit.sv
module loh_irq_ctrl_unit
  import loh_irq_pkg::*;
(
  input  logic        regAddr,
  input  logic        regWrEn,
  input  logic        regRdEn,
  output regStrobes_t strb
);
  always_comb begin
    strb.wrEnable  = regWrEn && (regAddr == ENABLE_ADDR);
    strb.clrStatus = regRdEn && (regAddr == STATUS_ADDR);
    strb.selStatus = (regAddr == STATUS_ADDR);
  end
endmodule

// File: rtl/loh_irq_datapath.sv
module loh_irq_datapath
  import loh_irq_pkg::*;
#(
  parameter int W = SRC_W,
  parameter logic [W-1:0] LVL_MASK = LEVEL_MASK
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [W-1:0]  srcIn,
  input  regStrobes_t   strb,
  input  logic [W-1:0]  wrData,
  output logic [W-1:0]  rdData,
  output logic          irqOut
);
  logic [W-1:0] evtVec;
  logic [W-1:0] hitVec;
  logic [W-1:0] enableReg;
  logic [W-1:0] statusReg;

  for (genvar i = 0; i < W; i++) begin : g_src
    if (LVL_MASK[i]) begin : g_level
      logic prevBit;
      always_ff @(posedge clk) begin
        if (!rstN) prevBit <= 1'b0;
        else       prevBit <= srcIn[i];
      end
      assign evtVec[i] = srcIn[i] ^ prevBit;
    end else begin : g_pulse
      assign evtVec[i] = srcIn[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) statusReg[i] <= 1'b0;
      else       statusReg[i] <= (statusReg[i] & ~strb.clrStatus) | hitVec[i];
    end
  end

  assign hitVec = evtVec & enableReg;

  always_ff @(posedge clk) begin
    if (!rstN)              enableReg <= '0;
    else if (strb.wrEnable) enableReg <= wrData;
  end

  assign rdData = strb.selStatus ? statusReg : enableReg;
  assign irqOut = |statusReg;

  // R4 R5 R7
  enabled_event_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> ((statusReg & $past(hitVec)) == $past(hitVec)));

  // R8
  masked_source_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statusReg & ~$past(statusReg) & ~$past(enableReg)) == '0));

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && !(|hitVec)) |=> (statusReg == '0));

  // R10
  read_keeps_new_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrStatus |=> ((statusReg & $past(hitVec)) == $past(hitVec)));

  // R11
  irq_follows_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> irqOut);
endmodule

// File: rtl/loh_irq_ctrl.sv
module loh_irq_ctrl
  import loh_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             losDefect,
  input  logic             sefDefect,
  input  logic             lofDefect,
  input  logic             sdDefect,
  input  logic             sfDefect,
  input  logic             secParityErr,
  input  logic             lineParityErr,
  input  logic             lineRemoteErr,
  input  logic             regAddr,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [SRC_W-1:0] regWrData,
  output logic [SRC_W-1:0] regRdData,
  output logic             irqOut
);
  logic [SRC_W-1:0] srcIn;
  regStrobes_t      strb;

  always_comb begin
    srcIn           = '0;
    srcIn[LOS_BIT]  = losDefect;
    srcIn[SEF_BIT]  = sefDefect;
    srcIn[LOF_BIT]  = lofDefect;
    srcIn[SEC_BIT]  = secParityErr;
    srcIn[LINE_BIT] = lineParityErr;
    srcIn[REM_BIT]  = lineRemoteErr;
    srcIn[SD_BIT]   = sdDefect;
    srcIn[SF_BIT]   = sfDefect;
  end

  loh_irq_ctrl_unit i_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .strb    (strb)
  );

  loh_irq_datapath #(.W(SRC_W), .LVL_MASK(LEVEL_MASK)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .srcIn  (srcIn),
    .strb   (strb),
    .wrData (regWrData),
    .rdData (regRdData),
    .irqOut (irqOut)
  );
endmodule

// File: tb/test_loh_irq_ctrl.sv
module test_loh_irq_ctrl;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic losDefect = 0, sefDefect = 0, lofDefect = 0, sdDefect = 0, sfDefect = 0;
  logic secParityErr = 0, lineParityErr = 0, lineRemoteErr = 0;
  logic regAddr = 0, regWrEn = 0, regRdEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  loh_irq_ctrl i_loh_irq_ctrl (
    .clk(clk), .rstN(rstN),
    .losDefect(losDefect), .sefDefect(sefDefect), .lofDefect(lofDefect),
    .sdDefect(sdDefect), .sfDefect(sfDefect),
    .secParityErr(secParityErr), .lineParityErr(lineParityErr),
    .lineRemoteErr(lineRemoteErr),
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .irqOut(irqOut)
  );

  // monitor: compares read data against the scoreboard queue
  always begin
    @(negedge clk);
    #1;
    if (regRdEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", regRdData);
      end else begin
        expItem_t it;
        it = expQ.pop_front();
        if (regRdData !== it.val) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, regRdData, it.val);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    regWrEn = 0; regRdEn = 0;
    secParityErr = 0; lineParityErr = 0; lineRemoteErr = 0;
  endtask

  task automatic writeEnable(input logic [7:0] v);
    step();
    regAddr = 1'b0; regWrEn = 1; regWrData = v;
  endtask

  task automatic readReg(input logic a, input logic [7:0] v, input string tag);
    expItem_t it;
    step();
    regAddr = a; regRdEn = 1;
    it.val = v; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic pulse(input logic s, input logic l, input logic r);
    step();
    secParityErr = s; lineParityErr = l; lineRemoteErr = r;
  endtask

  task automatic checkIrq(input logic e, input string tag);
    step();
    #1;
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s irqOut: actual %b expected %b", tag, irqOut, e);
    end
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    checkIrq(0, "R1");
    readReg(0, 8'h00, "R1 enable");
    readReg(1, 8'h00, "R1 status");
    // R2 enable write/readback
    writeEnable(8'hFF);
    readReg(0, 8'hFF, "R2 enable readback");
    // R4 rise of loss of signal -> bit0
    step(); losDefect = 1;
    checkIrq(1, "R11 R4");
    readReg(1, 8'h01, "R4 R3 los rise");
    checkIrq(0, "R11 cleared");
    readReg(1, 8'h00, "R9 cleared");
    // R6 steady level
    step(); step();
    readReg(1, 8'h00, "R6 steady");
    // R5 fall
    step(); losDefect = 0;
    readReg(1, 8'h01, "R5 los fall");
    // R3 several levels together: SF,SD,LOF,SEF -> C6
    step(); sfDefect = 1; sdDefect = 1; lofDefect = 1; sefDefect = 1;
    readReg(1, 8'hC6, "R3 R4 multi rise");
    // R7 pulses
    pulse(1, 0, 0);
    readReg(1, 8'h08, "R7 R3 section parity");
    pulse(0, 1, 0);
    readReg(1, 8'h10, "R7 R3 line parity");
    pulse(0, 0, 1);
    pulse(0, 0, 1);
    readReg(1, 8'h20, "R7 R3 remote error repeated");
    // R8 masked source
    writeEnable(8'hF7);
    pulse(1, 0, 0);
    checkIrq(0, "R8");
    readReg(1, 8'h00, "R8 masked");
    // R10 event coincides with read
    pulse(0, 1, 0);
    readReg(1, 8'h10, "R10 first read");
    lineParityErr = 1;
    readReg(1, 8'h10, "R10 kept");
    readReg(1, 8'h00, "R10 then cleared");
    // R9 enable read does not clear status
    step(); sdDefect = 0;
    readReg(0, 8'hF7, "R9 enable read");
    readReg(1, 8'h40, "R9 R5 status kept");
    checkIrq(0, "R11 final");
    step();
    step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule